// File: doc/BRIEF.md
# Watchdog Timer with Interrupt, Reset and Combined Modes

The block is a watchdog timer that counts pulses of a slow clock enable (`tick`) while it is armed. When the count reaches a selected terminal value, it raises an interrupt request, emits a one-cycle system reset pulse, or raises the interrupt first and resets on the next expiry. Software restarts the count with a kick strobe. A single write port carries an 8-bit control byte. Interrupt service is reported on a vector-acknowledge input. In combined mode, the acknowledge drops the block back to plain reset mode.

The reset-enable bit and the period select are protected. They change only through a two-step sequence: first a write with both the unlock bit and the reset-enable bit set, then a commit write, which must land within the next four clock cycles. The interrupt-enable bit and the flag-clear bit act on every write.

Control byte layout, with bits given high to low: bit 7 clears the flag when written as one; bit 6 is interrupt enable; bit 5 is unlock; bit 4 is reset enable; bits 3:0 are the period select.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `irq`, `rst_pulse` and `flag` are low, and reset enable, interrupt enable and select are zero. With both enables zero, the counter stays idle and no expiry happens, however many ticks arrive.
- R2: With the block armed, an expiry occurs after exactly 2^(BASE_LOG2+sel) ticks, counted from a kick or from the previous expiry. With BASE_LOG2=11, select 0 gives 2048 ticks and select 9 gives 1048576 ticks. Cycles without `tick` do not advance the count.
- R3: Select codes above STEPS-1 (9 by default) give the same period as select STEPS-1.
- R4: A kick returns the count to zero, so the next expiry comes a full period after the kick.
- R5: Interrupt-only mode is reset enable 0 and interrupt enable 1. In this mode an expiry sets `flag` and never pulses `rst_pulse`. `irq` is high exactly when `flag` and interrupt enable are both set.
- R6: Reset-only mode is reset enable 1 and interrupt enable 0. In this mode an expiry drives `rst_pulse` high for exactly one clock cycle and leaves `flag` low.
- R7: Combined mode is both enables set. The first expiry sets `flag` without a reset. `vec_ack` then clears both the flag and interrupt enable, so the next expiry resets. If the flag is still set when the next expiry arrives, that expiry resets.
- R8: A write with bit 5 = 1 and bit 4 = 1 opens a window covering the following four clock edges. A write with bit 5 = 0 inside the window loads reset enable from bit 4 and the select from bits 3:0. Loading both enables as zero stops the watchdog.
- R9: A write outside the window leaves reset enable and the select unchanged. This includes a write on the fifth edge after the unlock, and a write following an unlock attempt that had bit 4 = 0.
- R10: `flag` is cleared by `vec_ack` or by a write with bit 7 = 1. In interrupt-only mode, `vec_ack` keeps interrupt enable set, so the next expiry raises `irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow clock enable; each high cycle advances the count |
| kick | input | 1 | Restart strobe; clears the count |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte |
| vec_ack | input | 1 | Interrupt vector taken |
| irq | output | 1 | Interrupt request |
| rst_pulse | output | 1 | One-cycle system reset pulse |
| flag | output | 1 | Timeout flag |

## Verification
An expiry is registered. It shows on `flag` or `rst_pulse` at the edge where the count reaches its terminal value. That edge comes 2^(BASE_LOG2+sel) tick edges after the kick edge, and 2^(BASE_LOG2+sel)-1 edges after an acknowledge given on the edge right after an expiry. The bench samples on falling edges and counts from the kick edge, so a measured period can be compared to the computed power of two with no slack. A write takes effect on the edge that samples it. The unlock window is probed at the fourth edge, where the write is accepted, and at the fifth edge, where it is refused. The effect of each probe is then read back through the measured period.

// File: rtl/wdt_pkg.sv
// Package: shared control-byte type and sizing constants for the watchdog.
// Assumes an 8-bit control byte whose field positions are fixed by software.
package wdt_pkg;
    localparam int SEL_W = 4;

    typedef struct packed {
        logic             flag_clr;  // bit 7: write one to clear the flag
        logic             ie;        // bit 6: interrupt enable
        logic             unlock;    // bit 5: opens the change window
        logic             re;        // bit 4: reset enable
        logic [SEL_W-1:0] sel;       // bits 3:0: period select
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_unlock.sv
// Module: protected configuration holder. An unlock write (unlock and re both
// set) opens a window of WIN clock edges; a write without the unlock bit inside
// the window commits re and sel. Everything else leaves them untouched.
// Assumes at most one control write per cycle.
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  wdt_ctrl_t        wdata,
    output logic             cfg_re,
    output logic [SEL_W-1:0] cfg_sel,
    output logic             win_open
);
    localparam int WIN_W = $clog2(WIN + 1);

    logic [WIN_W-1:0] win_q;
    logic             key;
    logic             commit;

    assign key      = wr && wdata.unlock && wdata.re;
    assign win_open = (win_q != '0);
    assign commit   = wr && win_open && !wdata.unlock;

    // Window counter: reload on unlock, close on any other write, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_q <= '0;
        else if (key)      win_q <= WIN_W'(WIN);
        else if (wr)       win_q <= '0;
        else if (win_open) win_q <= win_q - 1'b1;
    end

    // Protected fields: load only on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_re  <= 1'b0;
            cfg_sel <= '0;
        end else if (commit) begin
            cfg_re  <= wdata.re;
            cfg_sel <= wdata.sel;
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
// Module: tick counter with selectable power-of-two terminal count.
// Expiry when the count has reached 2^(BASE_LOG2+sel)-1 on a tick; select codes
// beyond STEPS-1 saturate. Assumes STEPS <= 2^SEL_W and BASE_LOG2 >= 1.
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int STEPS     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int CNT_W   = BASE_LOG2 + STEPS - 1;
    localparam int MAX_SEL = STEPS - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic [SEL_W-1:0] eff_sel;

    // Saturate reserved select codes and form the terminal count.
    always_comb begin
        eff_sel = (int'(sel) > MAX_SEL) ? SEL_W'(MAX_SEL) : sel;
        term    = {CNT_W{1'b1}} >> (MAX_SEL - int'(eff_sel));
    end

    assign expire = run && tick && !kick && (cnt_q >= term);

    // Count ticks; kick or disarm clears, expiry wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || kick || !run) cnt_q <= '0;
        else if (expire)            cnt_q <= '0;
        else if (tick)              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_mode.sv
// Module: mode logic. Holds interrupt enable and the flag, and produces the
// registered reset pulse. In combined mode the vector acknowledge drops
// interrupt enable so the next expiry resets.
// Assumes expire is never high on two consecutive cycles.
module wdt_mode
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      expire,
    input  logic      cfg_re,
    input  logic      wr,
    input  wdt_ctrl_t wdata,
    input  logic      vec_ack,
    output logic      ie_en,
    output logic      flag,
    output logic      rst_pulse,
    output logic      irq
);
    // Interrupt enable: software write wins, otherwise service downgrade.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ie_en <= 1'b0;
        else if (wr)                ie_en <= wdata.ie;
        else if (vec_ack && cfg_re) ie_en <= 1'b0;
    end

    // Timeout flag: set by an expiry with interrupts on, cleared by service or write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                flag <= 1'b0;
        else if (expire && ie_en)                  flag <= 1'b1;
        else if (vec_ack || (wr && wdata.flag_clr)) flag <= 1'b0;
    end

    // Reset pulse: expiry with reset enabled and no pending-free interrupt stage.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= expire && cfg_re && (!ie_en || flag);
    end

    assign irq = flag && ie_en;
endmodule

// File: rtl/wdt_guard.sv
// Module: watchdog top. Ties the protected configuration, the tick counter and
// the mode logic together. The counter runs while either enable is set.
// Assumes tick is a single-cycle enable synchronous to clk.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int STEPS     = 10,
    parameter int WIN       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       kick,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    input  logic       vec_ack,
    output logic       irq,
    output logic       rst_pulse,
    output logic       flag
);
    wdt_ctrl_t        wdata;
    logic             cfg_re;
    logic [SEL_W-1:0] cfg_sel;
    logic             win_open;
    logic             ie_en;
    logic             expire;
    logic             run;

    assign wdata = wdt_ctrl_t'(ctrl_wdata);
    assign run   = cfg_re || ie_en;

    wdt_unlock #(.WIN(WIN)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(wdata),
        .cfg_re(cfg_re), .cfg_sel(cfg_sel), .win_open(win_open)
    );

    wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .STEPS(STEPS)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .kick(kick),
        .sel(cfg_sel), .expire(expire)
    );

    wdt_mode u_mode (
        .clk(clk), .rst_n(rst_n), .expire(expire), .cfg_re(cfg_re),
        .wr(ctrl_wr), .wdata(wdata), .vec_ack(vec_ack), .ie_en(ie_en),
        .flag(flag), .rst_pulse(rst_pulse), .irq(irq)
    );
endmodule

// File: rtl/wdt_guard_chk.sv
// Module: property checker for wdt_guard, attached by bind.
// Assumes the control byte layout of wdt_pkg (bit 5 unlock, bit 4 re, bits 3:0 sel).
module wdt_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       rst_pulse,
    input logic       flag,
    input logic       vec_ack,
    input logic       expire,
    input logic       cfg_re,
    input logic [3:0] cfg_sel,
    input logic       ie_en,
    input logic       win_open,
    input logic       ctrl_wr,
    input logic [7:0] ctrl_wdata
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !rst_pulse && !flag));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    assert_first_is_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cfg_re && ie_en && !flag) |=> (flag && !rst_pulse));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !expire) |=> !flag);

    assert_locked_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && win_open) |=> ($stable(cfg_re) && $stable(cfg_sel)));

    assert_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && win_open && !ctrl_wdata[5]) |=>
            (cfg_re == $past(ctrl_wdata[4]) && cfg_sel == $past(ctrl_wdata[3:0])));
endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .rst_pulse(rst_pulse), .flag(flag),
    .vec_ack(vec_ack), .expire(expire), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
    .ie_en(ie_en), .win_open(win_open), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata)
);

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
    localparam int BASE = 2;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, kick = 1'b0;
    logic       ctrl_wr = 1'b0, vec_ack = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       irq, rst_pulse, flag;

    int checks = 0, fails = 0, rst_seen = 0, wide = 0;
    bit prev_pulse = 1'b0;

    wdt_guard #(.BASE_LOG2(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .vec_ack(vec_ack), .irq(irq),
        .rst_pulse(rst_pulse), .flag(flag)
    );

    always #2.5 clk = ~clk;

    // Reset pulse monitor: counts pulses and pulses wider than one cycle.
    always @(negedge clk) begin
        if (rst_pulse) begin
            rst_seen++;
            if (prev_pulse) wide++;
        end
        prev_pulse = rst_pulse;
    end

    function automatic int period(int sel);
        return 1 << (BASE + ((sel > 9) ? 9 : sel));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        ctrl_wdata = b; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_wdata = 8'h00;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic do_ack();
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
    endtask

    task automatic cfg(bit ie, bit re, logic [3:0] sel);
        wr({1'b0, ie, 1'b1, 1'b1, 4'd0});
        wr({1'b0, ie, 1'b0, re, sel});
    endtask

    task automatic wait_ev(bit want_rst, int limit, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (want_rst ? rst_pulse : flag) break;
            if (n >= limit) begin n = -1; break; end
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, r0;
        tick = 1'b1;
        idle(3);
        check(!irq && !rst_pulse && !flag, "R1 reset outputs", {irq, rst_pulse, flag}, 0);
        rst_n = 1'b1;
        idle(3000);
        check(rst_seen == 0 && !flag, "R1 idle after reset", rst_seen + flag, 0);

        // R2/R3: sweep every select code in reset-only mode.
        for (int s = 0; s < 16; s++) begin
            cfg(1'b0, 1'b1, 4'(s));
            do_kick();
            wait_ev(1'b1, 4100, n);
            check(n == period(s), (s > 9) ? "R3 saturated period" : "R2 period", n, period(s));
            check(!flag, "R6 no flag in reset mode", flag, 0);
        end

        // R2: no ticks, no progress.
        cfg(1'b0, 1'b1, 4'd1);
        do_kick();
        tick = 1'b0;
        r0 = rst_seen;
        idle(100);
        check(rst_seen == r0, "R2 tick gating", rst_seen - r0, 0);
        tick = 1'b1;
        wait_ev(1'b1, 100, n);
        check(n == 8, "R2 resume count", n, 8);

        // R4: kick mid-period restarts the count.
        cfg(1'b0, 1'b1, 4'd2);
        do_kick();
        r0 = rst_seen;
        idle(10);
        do_kick();
        check(rst_seen == r0, "R4 no expiry before kick", rst_seen - r0, 0);
        wait_ev(1'b1, 100, n);
        check(n == 16, "R4 period after kick", n, 16);

        // R5: interrupt-only mode.
        cfg(1'b1, 1'b0, 4'd1);
        wr(8'hC0);
        do_kick();
        r0 = rst_seen;
        wait_ev(1'b0, 100, n);
        check(n == 8, "R5 flag period", n, 8);
        check(irq == 1'b1, "R5 irq raised", irq, 1);
        idle(20);
        check(rst_seen == r0, "R5 no reset", rst_seen - r0, 0);
        wr(8'h00);
        check(!irq && flag, "R5 irq gated by enable", {irq, flag}, 1);
        wr(8'h80);
        check(!flag, "R10 write clears flag", flag, 0);

        // R10: acknowledge in interrupt-only mode keeps the enable.
        cfg(1'b1, 1'b0, 4'd1);
        do_kick();
        wait_ev(1'b0, 100, n);
        do_ack();
        check(!flag && !irq, "R10 ack clears flag", {flag, irq}, 0);
        wait_ev(1'b0, 100, n);
        check(n == 7 && irq, "R10 irq again after ack", n, 7);

        // R7: combined mode, serviced.
        cfg(1'b1, 1'b1, 4'd1);
        wr(8'hC0);
        do_kick();
        r0 = rst_seen;
        wait_ev(1'b0, 100, n);
        check(n == 8 && rst_seen == r0, "R7 first expiry is irq", n, 8);
        do_ack();
        check(!flag && !irq, "R7 ack drops irq", {flag, irq}, 0);
        wait_ev(1'b1, 100, n);
        check(n == 7, "R7 reset after service", n, 7);
        check(!flag, "R7 no flag on reset", flag, 0);

        // R7: combined mode, unserviced.
        wr(8'h40);
        do_kick();
        wait_ev(1'b0, 100, n);
        check(n == 8, "R7 unserviced flag", n, 8);
        wait_ev(1'b1, 100, n);
        check(n == 8, "R7 unserviced reset", n, 8);

        // R9: unprotected write ignored.
        wr(8'h80);
        wr(8'h02);
        do_kick();
        wait_ev(1'b1, 100, n);
        check(n == 8, "R9 plain write ignored", n, 8);

        // R9: commit on the fifth edge refused.
        wr(8'h30);
        idle(4);
        wr(8'h12);
        do_kick();
        wait_ev(1'b1, 100, n);
        check(n == 8, "R9 late commit refused", n, 8);

        // R8: commit on the fourth edge accepted.
        wr(8'h30);
        idle(3);
        wr(8'h12);
        do_kick();
        wait_ev(1'b1, 100, n);
        check(n == 16, "R8 commit in window", n, 16);

        // R9: unlock without reset enable does not open the window.
        wr(8'h20);
        wr(8'h11);
        do_kick();
        wait_ev(1'b1, 100, n);
        check(n == 16, "R9 bad unlock", n, 16);

        // R8: disable through the sequence.
        cfg(1'b0, 1'b0, 4'd0);
        r0 = rst_seen;
        idle(3000);
        check(rst_seen == r0 && !flag, "R8 disabled", rst_seen - r0, 0);

        check(wide == 0, "R6 pulse width", wide, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule